// File: doc/BRIEF.md
# Micro-Tiled Surface Detile Address Generator

This block walks every pixel of a three-dimensional surface that is stored in 8x8 micro tiles and, for each pixel, issues one copy descriptor to an external copy engine. A descriptor carries three values. The first is the byte address of the pixel in the tiled source buffer. The second is the byte address of the same pixel in a linear destination buffer. The third is the number of bytes to copy, which is always the element size.

Software starts a run with a one-cycle `start` pulse. The surface width, height and depth, the element size and the tiling mode are sampled with that pulse. The block then visits pixels in slice order, row order within a slice and column order within a row. It holds each descriptor while the consumer refuses it and offers a new one every cycle while the consumer accepts. A single-cycle `done` marks the end of a run. A run with an empty dimension, or with an element size the block cannot handle, ends at once and issues no descriptors. An unsupported element size also raises `error`.

Top module: `detile_agen`

## Requirements
- R1: After reset, `desc_valid`, `done`, `error` and `busy` are all low.
- R2: A run accepted from idle issues exactly width×height×depth descriptors. Depth is the outermost loop, then rows, and columns step fastest.
- R3: The destination address of pixel (x,y,z) is ((z×height + y)×width + x)×bpe.
- R4: For `tile_mode` 1 or 2 (interleaved modes), the source address is (T×64 + E)×bpe. T = (z×ceil(height/8) + y/8)×ceil(width/8) + x/8, where division truncates. E holds x0, y0, x1, y1, x2, y2 in bits 0 to 5.
- R5: For `tile_mode` 0 or 3, E is zero, so the source address is T×64×bpe.
- R6: `desc_len` equals the sampled bpe on every descriptor. The legal bpe values are 1, 2, 4, 8 and 16.
- R7: While `desc_valid` is high and `desc_ready` is low, the next cycle keeps `desc_valid` high and all three descriptor fields unchanged.
- R8: With `desc_ready` held high, one descriptor is accepted per cycle, with no gap cycles.
- R9: If width, height or depth is zero, `done` is high in the cycle after `start` is sampled. No descriptor is issued and `error` stays low.
- R10: If bpe is not a legal value, `done` and `error` are high in the cycle after `start` is sampled, and no descriptor is issued. The bpe check takes precedence over R9. `error` stays high until the next accepted start, which clears it.
- R11: `done` is high for exactly one cycle: the cycle after the last descriptor is accepted. `desc_valid` is low while `done` is high.
- R12: A `start` pulse while `busy` is high is ignored. The running traversal, its sampled parameters and its descriptors are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| width | input | DW | Surface width in pixels |
| height | input | DW | Surface height in pixels |
| depth | input | DW | Number of slices |
| bpe | input | 5 | Bytes per element |
| tile_mode | input | 2 | Micro tile mode (1 and 2 interleave) |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run used an unsupported bpe |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Consumer accepts descriptor |
| desc_src | output | AW | Tiled source byte address |
| desc_dst | output | AW | Linear destination byte address |
| desc_len | output | 5 | Copy length in bytes |

## Verification
The properties assume that reset is asserted from time zero. They also assume that `desc_ready` is an ordinary consumer signal that may change in any cycle. The destination-step property relies on the sampled bpe being constant for the whole run. This holds because parameters are sampled only at an accepted start. The stimulus keeps dimensions small enough that every address fits in the address width. It varies `desc_ready` with fixed gap patterns, and changes the parameter inputs only at start, apart from a deliberate mid-run change that exercises R12.

// File: rtl/detile_pkg.sv
package detile_pkg;
  localparam int BPE_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} dt_state_e;

  function automatic logic bpe_legal(input logic [BPE_W-1:0] b);
    return (b == 5'd1) || (b == 5'd2) || (b == 5'd4) || (b == 5'd8) || (b == 5'd16);
  endfunction

  function automatic logic [2:0] bpe_log2(input logic [BPE_W-1:0] b);
    logic [2:0] r;
    case (b)
      5'd2:    r = 3'd1;
      5'd4:    r = 3'd2;
      5'd8:    r = 3'd3;
      5'd16:   r = 3'd4;
      default: r = 3'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/detile_walker.sv
module detile_walker #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] h,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] x,
  output logic [DW-1:0] y,
  output logic          x_last,
  output logic          y_last,
  output logic          last
);
  logic [DW-1:0] x_q, y_q, z_q, x_d, y_d, z_d;
  logic          z_last;

  assign x_last = (x_q == w - DW'(1));
  assign y_last = (y_q == h - DW'(1));
  assign z_last = (z_q == d - DW'(1));
  assign last   = x_last && y_last && z_last;
  assign x      = x_q;
  assign y      = y_q;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    z_d = z_q;
    if (clr) begin
      x_d = '0;
      y_d = '0;
      z_d = '0;
    end else if (step) begin
      if (x_last) begin
        x_d = '0;
        if (y_last) begin
          y_d = '0;
          z_d = z_q + DW'(1);
        end else begin
          y_d = y_q + DW'(1);
        end
      end else begin
        x_d = x_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (clr || step) begin
      x_q <= x_d;
      y_q <= y_d;
      z_q <= z_d;
    end
  end
endmodule

// File: rtl/detile_morton.sv
module detile_morton #(
  parameter int TL = 3
) (
  input  logic [TL-1:0]   x_lo,
  input  logic [TL-1:0]   y_lo,
  input  logic            en,
  output logic [2*TL-1:0] elem
);
  for (genvar i = 0; i < TL; i++) begin : g_bit
    assign elem[2*i]   = en & x_lo[i];
    assign elem[2*i+1] = en & y_lo[i];
  end
endmodule

// File: rtl/detile_agen.sv
module detile_agen
  import detile_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    width,
  input  logic [DW-1:0]    height,
  input  logic [DW-1:0]    depth,
  input  logic [BPE_W-1:0] bpe,
  input  logic [1:0]       tile_mode,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [AW-1:0]    desc_src,
  output logic [AW-1:0]    desc_dst,
  output logic [BPE_W-1:0] desc_len
);
  localparam int TL = 3;
  localparam int EW = 2 * TL;
  localparam int NW = 3 * DW;

  dt_state_e        st_q, st_d;
  logic [DW-1:0]    w_q, h_q, d_q;
  logic [2:0]       sh_q;
  logic [BPE_W-1:0] len_q;
  logic             il_q, err_q;
  logic [NW-1:0]    tpr_q, tps_q, rowb_q, slcb_q, lin_q;
  logic [NW-1:0]    rowb_d, slcb_d, lin_d;

  logic [DW:0]      wr, hr;
  logic [NW-1:0]    tpr_in, tph_in, tps_in, tile;
  logic             go, zero_in, ok_in, fire, adv;
  logic [DW-1:0]    x, y;
  logic             x_last, y_last, last;
  logic [EW-1:0]    elem;
  logic [AW-1:0]    src_raw;

  assign wr      = {1'b0, width}  + (DW+1)'(7);
  assign hr      = {1'b0, height} + (DW+1)'(7);
  assign tpr_in  = NW'(wr >> TL);
  assign tph_in  = NW'(hr >> TL);
  assign tps_in  = tpr_in * tph_in;
  assign go      = (st_q == ST_IDLE) && start;
  assign zero_in = (width == '0) || (height == '0) || (depth == '0);
  assign ok_in   = bpe_legal(bpe);
  assign fire    = (st_q == ST_RUN) && desc_ready;
  assign adv     = fire && !last;

  detile_walker #(.DW(DW)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(go), .step(adv),
    .w(w_q), .h(h_q), .d(d_q),
    .x(x), .y(y), .x_last(x_last), .y_last(y_last), .last(last)
  );

  detile_morton #(.TL(TL)) u_mort (
    .x_lo(x[TL-1:0]), .y_lo(y[TL-1:0]), .en(il_q), .elem(elem)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = (!ok_in || zero_in) ? ST_FIN : ST_RUN;
      ST_RUN:  if (fire && last) st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rowb_d = rowb_q;
    slcb_d = slcb_q;
    lin_d  = lin_q;
    if (go) begin
      rowb_d = '0;
      slcb_d = '0;
      lin_d  = '0;
    end else if (adv) begin
      lin_d = lin_q + NW'(1);
      if (x_last) begin
        if (y_last) begin
          rowb_d = '0;
          slcb_d = slcb_q + tps_q;
        end else if (&y[TL-1:0]) begin
          rowb_d = rowb_q + tpr_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      w_q    <= '0;
      h_q    <= '0;
      d_q    <= '0;
      sh_q   <= '0;
      len_q  <= '0;
      il_q   <= 1'b0;
      err_q  <= 1'b0;
      tpr_q  <= '0;
      tps_q  <= '0;
      rowb_q <= '0;
      slcb_q <= '0;
      lin_q  <= '0;
    end else begin
      st_q <= st_d;
      if (go) begin
        w_q   <= width;
        h_q   <= height;
        d_q   <= depth;
        sh_q  <= bpe_log2(bpe);
        len_q <= bpe;
        il_q  <= (tile_mode == 2'd1) || (tile_mode == 2'd2);
        err_q <= !ok_in;
        tpr_q <= tpr_in;
        tps_q <= tps_in;
      end
      if (go || adv) begin
        rowb_q <= rowb_d;
        slcb_q <= slcb_d;
        lin_q  <= lin_d;
      end
    end
  end

  assign tile       = slcb_q + rowb_q + NW'(x >> TL);
  assign src_raw    = (AW'(tile) << EW) | AW'(elem);
  assign desc_src   = src_raw << sh_q;
  assign desc_dst   = AW'(lin_q) << sh_q;
  assign desc_len   = len_q;
  assign desc_valid = (st_q == ST_RUN);
  assign done       = (st_q == ST_FIN);
  assign busy       = (st_q != ST_IDLE);
  assign error      = err_q;
endmodule

// File: rtl/detile_agen_chk.sv
module detile_agen_chk #(
  parameter int AW = 32,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic [AW-1:0] desc_src,
  input logic [AW-1:0] desc_dst,
  input logic [LW-1:0] desc_len
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_src) && $stable(desc_dst) && $stable(desc_len)); // R7

  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(desc_valid && desc_ready) && desc_valid |-> desc_dst == $past(desc_dst) + AW'(desc_len)); // R3

  AST_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $countones(desc_len) == 1); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !desc_valid && busy); // R11

  AST_ERR_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !desc_valid); // R10
endmodule

bind detile_agen detile_agen_chk #(.AW(AW), .LW(detile_pkg::BPE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len)
);

// File: tb/detile_agen_bench.sv
`timescale 1ns/1ps
module detile_agen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  width = '0, height = '0, depth = '0;
  logic [4:0]  bpe = '0;
  logic [1:0]  tile_mode = '0;
  logic        desc_ready = 1'b0;
  logic        busy, done, error, desc_valid;
  logic [31:0] desc_src, desc_dst;
  logic [4:0]  desc_len;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  detile_agen u_detile_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .width(width), .height(height),
    .depth(depth), .bpe(bpe), .tile_mode(tile_mode), .busy(busy), .done(done),
    .error(error), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len)
  );

  typedef struct packed { int w; int h; int d; int b; int m; int rp; } case_t;
  localparam int NC = 6;
  localparam case_t CASES [NC] = '{
    '{8, 8, 1, 4, 1, 0},
    '{13, 5, 2, 2, 2, 1},
    '{16, 9, 1, 1, 0, 0},
    '{3, 3, 3, 16, 3, 2},
    '{20, 17, 1, 8, 1, 1},
    '{1, 1, 1, 4, 2, 0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_src(int x, int y, int z, int w, int h, int b, int m);
    int tpr, tph, t, e;
    tpr = (w + 7) / 8;
    tph = (h + 7) / 8;
    t = (z * tph + y / 8) * tpr + x / 8;
    e = 0;
    if (m == 1 || m == 2)
      e = (x & 1) | ((y & 1) << 1) | (((x >> 1) & 1) << 2) | (((y >> 1) & 1) << 3)
        | (((x >> 2) & 1) << 4) | (((y >> 2) & 1) << 5);
    return longint'((t * 64 + e) * b);
  endfunction

  function automatic longint ref_dst(int x, int y, int z, int w, int h, int b);
    return longint'(((z * h + y) * w + x) * b);
  endfunction

  function automatic bit rdy_of(int rp, int c);
    if (rp == 1) return (c % 3) != 0;
    if (rp == 2) return (c % 2) == 1;
    return 1'b1;
  endfunction

  task automatic run_case(input case_t c, input bit poke);
    int ex, ey, ez, got, src_bad, dst_bad, len_bad, stall_bad, cyc, vcyc, lastc, donec;
    logic [31:0] hs, hd;
    bit hold, fin, r;
    ex = 0; ey = 0; ez = 0; got = 0; src_bad = 0; dst_bad = 0; len_bad = 0;
    stall_bad = 0; cyc = 0; vcyc = 0; lastc = -5; donec = -1; hold = 0; fin = 0;
    @(negedge clk);
    width = 8'(c.w); height = 8'(c.h); depth = 8'(c.d); bpe = 5'(c.b); tile_mode = 2'(c.m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 5000) begin
      if (hold && (!desc_valid || desc_src != hs || desc_dst != hd)) stall_bad++;
      if (done) begin
        fin = 1;
        donec = cyc;
        chk(!desc_valid, "R11", "valid during done", longint'(desc_valid), 0);
      end else begin
        if (poke && cyc == 2) begin
          start = 1'b1; width = 8'd0; bpe = 5'd3; tile_mode = 2'd0;
        end
        if (poke && cyc == 3) start = 1'b0;
        r = rdy_of(c.rp, cyc);
        desc_ready = r;
        if (desc_valid) begin
          vcyc++;
          if (r) begin
            if (longint'(desc_src) != ref_src(ex, ey, ez, c.w, c.h, c.b, c.m)) begin
              if (src_bad == 0)
                $display("INFO src mismatch at (%0d,%0d,%0d) got %0d want %0d", ex, ey, ez,
                         desc_src, ref_src(ex, ey, ez, c.w, c.h, c.b, c.m));
              src_bad++;
            end
            if (longint'(desc_dst) != ref_dst(ex, ey, ez, c.w, c.h, c.b)) dst_bad++;
            if (int'(desc_len) != c.b) len_bad++;
            got++;
            lastc = cyc;
            ex++;
            if (ex == c.w) begin
              ex = 0; ey++;
              if (ey == c.h) begin ey = 0; ez++; end
            end
          end
          hold = !r;
          hs = desc_src;
          hd = desc_dst;
        end else begin
          hold = 0;
        end
        @(negedge clk);
        cyc++;
      end
    end
    desc_ready = 1'b0;
    chk(got == c.w * c.h * c.d, poke ? "R12" : "R2", "descriptor count", got, c.w * c.h * c.d);
    chk(dst_bad == 0, "R3", "dst mismatches", dst_bad, 0);
    if (c.m == 1 || c.m == 2) chk(src_bad == 0, "R4", "src mismatches", src_bad, 0);
    else                      chk(src_bad == 0, "R5", "src mismatches", src_bad, 0);
    chk(len_bad == 0, "R6", "len mismatches", len_bad, 0);
    chk(stall_bad == 0, "R7", "stall changes", stall_bad, 0);
    if (c.rp == 0) chk(vcyc == got, "R8", "valid cycles", vcyc, got);
    chk(donec == lastc + 1, "R11", "done cycle", donec, lastc + 1);
    chk(error == 1'b0, poke ? "R12" : "R10", "error after good run", longint'(error), 0);
    @(negedge clk);
    chk(!done, "R11", "done second cycle", longint'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!desc_valid && !done && !error && !busy, "R1", "reset outputs",
        longint'({desc_valid, done, error, busy}), 0);

    for (int i = 0; i < NC; i++) run_case(CASES[i], 1'b0);

    // R9: zero dimension in width, then in depth
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      width = (k == 0) ? 8'd0 : 8'd4; height = 8'd4; depth = (k == 0) ? 8'd2 : 8'd0;
      bpe = 5'd4; tile_mode = 2'd1; start = 1'b1; desc_ready = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !desc_valid && !error, "R9", "zero dim end",
          longint'({done, desc_valid, error}), 4);
      @(negedge clk);
      chk(!done && !desc_valid && !busy, "R9", "zero dim idle after",
          longint'({done, desc_valid, busy}), 0);
    end
    desc_ready = 1'b0;

    // R10: illegal element size, also with zero dims
    @(negedge clk);
    width = 8'd0; height = 8'd4; depth = 8'd1; bpe = 5'd3; start = 1'b1; desc_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && error && !desc_valid, "R10", "bad bpe end",
        longint'({done, error, desc_valid}), 6);
    repeat (3) @(negedge clk);
    chk(error && !desc_valid && !done, "R10", "error held",
        longint'({error, desc_valid, done}), 4);
    @(negedge clk);
    width = 8'd4; bpe = 5'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && error, "R10", "bpe zero rejected", longint'({done, error}), 3);
    desc_ready = 1'b0;

    // R10: a legal start clears error; R12: mid-run start ignored
    run_case('{4, 4, 1, 4, 1, 0}, 1'b1);
    run_case('{9, 10, 2, 2, 0, 2}, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule